// File: doc/BRIEF.md
# Configuration Word Loader with Byte-Sum Validation

This block fetches a block of configuration words from a non-volatile store as soon as reset is released. It issues word-read requests one at a time in ascending address order. Each returned word is copied out on a register-file write port. Both bytes of every word are also folded into an 8-bit running sum.

After the final word has been taken in, the block raises a completion flag. It also publishes whether the byte sum matched the expected constant 0xFF. When the sum does not match, the stored data is treated as untrustworthy and a fallback-mode bit is raised. Downstream logic uses that bit to switch into a relocatable configuration scheme.

The store's bit-level serial protocol is not part of this block. A word-level request/response handshake stands in for it.

Top module: `cfg_cksum_loader`

## Requirements
- R1: While `rst_n` is low, `rd_req`, `cfg_we`, `done`, `sum_ok` and `reloc_mode` are all 0.
- R2: On the first clock edge after reset is released, `rd_req` rises with `rd_addr` = 0. No other input is needed to start the sequence.
- R3: A word is accepted on a clock edge where `rd_req` and `rd_valid` are both 1. While a request waits without `rd_valid`, `rd_addr` holds its value. After each acceptance below the last address, the next request carries the previous address plus one. Only one request is ever open at a time.
- R4: On the cycle after each acceptance, `cfg_we` is 1, `cfg_waddr` equals the accepted address and `cfg_wdata` equals the accepted data. In every other cycle `cfg_we` is 0. Exactly 27 writes occur per load.
- R5: The checksum is the sum, modulo 256, of bits [7:0] and bits [15:8] of every word at addresses 0x00 to 0x1A inclusive. Carries out of bit 7 are dropped.
- R6: `done` stays 0 until word 0x1A has been accepted and rises in the cycle after that acceptance. From then on, `rd_req` is 0.
- R7: When `done` is 1, `sum_ok` is 1 exactly when the checksum equals 0xFF, and `reloc_mode` is 1 exactly when it does not. Both are 0 while `done` is 0.
- R8: Once `done` is 1, `done`, `sum_ok` and `reloc_mode` keep their values until the next reset. Any `rd_valid` pulse while `rd_req` is 0 causes no write and changes no output.
- R9: The result does not depend on response latency. Idle cycles between request and response, with arbitrary `rd_data` while `rd_valid` is 0, leave the writes and the verdict unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | output | 1 | Word-read request open |
| rd_addr | output | 6 | Word address of the open request |
| rd_data | input | 16 | Returned word |
| rd_valid | input | 1 | Returned word is valid this cycle |
| cfg_we | output | 1 | Register-file write strobe |
| cfg_waddr | output | 6 | Register-file write address |
| cfg_wdata | output | 16 | Register-file write data |
| done | output | 1 | Load complete |
| sum_ok | output | 1 | Byte sum matched 0xFF |
| reloc_mode | output | 1 | Fallback relocatable mode selected |

## Verification
The load is run with several word images:
- one tuned to sum exactly to 0xFF;
- one that is all zero;
- one of all-ones words, where every byte add carries;
- one tuned to 0xFE, one below the target.

Together these separate a correct verdict from an inverted one, and from one that sums only a single byte or keeps carries. Each image is served with zero wait cycles or with address-dependent wait cycles, with junk on the data bus while `rd_valid` is 0. This shows that acceptance is tied to the handshake and not to the bus contents. After completion, stray `rd_valid` pulses test that the verdict is frozen and that no extra writes leak out.

// File: rtl/cfg_cksum_pkg.sv
package cfg_cksum_pkg;

   typedef enum logic [1:0] {
      LD_START  = 2'd0,
      LD_FETCH  = 2'd1,
      LD_FINISH = 2'd2
   } ld_state_t;

   // Modular add of two sum-width values; carry out is dropped.
   function automatic logic [7:0] wrap_add8(input logic [7:0] a, input logic [7:0] b);
      logic [8:0] full;
      full = {1'b0, a} + {1'b0, b};
      return full[7:0];
   endfunction

endpackage

// File: rtl/ccl_seq.sv
module ccl_seq
   import cfg_cksum_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int FIRST_ADDR = 0,
   parameter int LAST_ADDR  = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_valid,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              accept,
   output logic              last_accept
);

   localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(FIRST_ADDR);
   localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(LAST_ADDR);

   ld_state_t         state_q, state_d;
   logic [ADDR_W-1:0] addr_q, addr_d;

   assign rd_req      = (state_q == LD_FETCH);
   assign rd_addr     = addr_q;
   assign accept      = rd_req & rd_valid;
   assign last_accept = accept & (addr_q == LAST_A);

   always_comb begin
      state_d = state_q;
      addr_d  = addr_q;
      unique case (state_q)
         LD_START: begin
            state_d = LD_FETCH;
            addr_d  = FIRST_A;
         end
         LD_FETCH: begin
            if (last_accept) begin
               state_d = LD_FINISH;
            end else if (accept) begin
               addr_d = addr_q + 1'b1;
            end
         end
         LD_FINISH: begin
            state_d = LD_FINISH;
         end
         default: begin
            state_d = LD_START;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LD_START;
         addr_q  <= FIRST_A;
      end else begin
         state_q <= state_d;
         addr_q  <= addr_d;
      end
   end

endmodule

// File: rtl/ccl_accum.sv
module ccl_accum
   import cfg_cksum_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SUM_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] word,
   output logic [SUM_W-1:0]  sum_q,
   output logic [SUM_W-1:0]  sum_next
);

   localparam int LANES = DATA_W / SUM_W;

   logic [SUM_W-1:0] word_sum;

   generate
      if (LANES == 1) begin : g_single
         assign word_sum = word[SUM_W-1:0];
      end else begin : g_multi
         logic [SUM_W-1:0] part [LANES];
         assign part[0] = word[SUM_W-1:0];
         for (genvar i = 1; i < LANES; i++) begin : g_lane
            assign part[i] = SUM_W'(part[i-1] + word[i*SUM_W +: SUM_W]);
         end
         assign word_sum = part[LANES-1];
      end
   endgenerate

   assign sum_next = accept ? SUM_W'(sum_q + word_sum) : sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
      end else begin
         sum_q <= sum_next;
      end
   end

endmodule

// File: rtl/ccl_wrport.sv
module ccl_wrport #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output logic [DATA_W-1:0] wdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we    <= 1'b0;
         waddr <= '0;
         wdata <= '0;
      end else begin
         we <= accept;
         if (accept) begin
            waddr <= addr_in;
            wdata <= data_in;
         end
      end
   end

endmodule

// File: rtl/ccl_verdict.sv
module ccl_verdict #(
   parameter int               SUM_W    = 8,
   parameter logic [SUM_W-1:0] GOOD_SUM = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             last_accept,
   input  logic [SUM_W-1:0] sum_next,
   output logic             done,
   output logic             sum_ok,
   output logic             reloc_mode
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done       <= 1'b0;
         sum_ok     <= 1'b0;
         reloc_mode <= 1'b0;
      end else if (last_accept && !done) begin
         done       <= 1'b1;
         sum_ok     <= (sum_next == GOOD_SUM);
         reloc_mode <= (sum_next != GOOD_SUM);
      end
   end

endmodule

// File: rtl/cfg_cksum_loader.sv
module cfg_cksum_loader
   import cfg_cksum_pkg::*;
#(
   parameter int               ADDR_W     = 6,
   parameter int               DATA_W     = 16,
   parameter int               SUM_W      = 8,
   parameter int               FIRST_ADDR = 0,
   parameter int               LAST_ADDR  = 26,
   parameter logic [SUM_W-1:0] GOOD_SUM   = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_valid,
   output logic              cfg_we,
   output logic [ADDR_W-1:0] cfg_waddr,
   output logic [DATA_W-1:0] cfg_wdata,
   output logic              done,
   output logic              sum_ok,
   output logic              reloc_mode
);

   generate
      if (DATA_W % SUM_W != 0) begin : g_bad_width
         $error("DATA_W must be a whole number of SUM_W lanes");
      end
      if (LAST_ADDR < FIRST_ADDR) begin : g_bad_range
         $error("LAST_ADDR must not be below FIRST_ADDR");
      end
      if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("LAST_ADDR does not fit in ADDR_W bits");
      end
   endgenerate

   logic             accept;
   logic             last_accept;
   logic [SUM_W-1:0] sum_q;
   logic [SUM_W-1:0] sum_next;

   ccl_seq #(
      .ADDR_W    (ADDR_W),
      .FIRST_ADDR(FIRST_ADDR),
      .LAST_ADDR (LAST_ADDR)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_valid   (rd_valid),
      .rd_req     (rd_req),
      .rd_addr    (rd_addr),
      .accept     (accept),
      .last_accept(last_accept)
   );

   ccl_accum #(
      .DATA_W(DATA_W),
      .SUM_W (SUM_W)
   ) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .word    (rd_data),
      .sum_q   (sum_q),
      .sum_next(sum_next)
   );

   ccl_wrport #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_wr (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .addr_in(rd_addr),
      .data_in(rd_data),
      .we     (cfg_we),
      .waddr  (cfg_waddr),
      .wdata  (cfg_wdata)
   );

   ccl_verdict #(
      .SUM_W   (SUM_W),
      .GOOD_SUM(GOOD_SUM)
   ) u_verdict (
      .clk        (clk),
      .rst_n      (rst_n),
      .last_accept(last_accept),
      .sum_next   (sum_next),
      .done       (done),
      .sum_ok     (sum_ok),
      .reloc_mode (reloc_mode)
   );

endmodule

// File: rtl/cfg_cksum_loader_chk.sv
module cfg_cksum_loader_chk #(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 16,
   parameter int LAST_ADDR = 26
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_valid,
   input logic              cfg_we,
   input logic [ADDR_W-1:0] cfg_waddr,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic              done,
   input logic              sum_ok,
   input logic              reloc_mode
);

   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

   // R3
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_valid && rd_addr != LAST_A) |=>
         (rd_req && rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

   // R4
   write_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_valid) |=>
         (cfg_we && cfg_waddr == $past(rd_addr) && cfg_wdata == $past(rd_data)));

   // R4
   no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && rd_valid) |=> !cfg_we);

   // R6
   idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rd_req);

   // R7
   verdict_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (!sum_ok && !reloc_mode));

   // R7
   verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (sum_ok != reloc_mode));

   // R8
   verdict_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && $stable(sum_ok) && $stable(reloc_mode)));

endmodule

bind cfg_cksum_loader cfg_cksum_loader_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .LAST_ADDR(LAST_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_req    (rd_req),
   .rd_addr   (rd_addr),
   .rd_data   (rd_data),
   .rd_valid  (rd_valid),
   .cfg_we    (cfg_we),
   .cfg_waddr (cfg_waddr),
   .cfg_wdata (cfg_wdata),
   .done      (done),
   .sum_ok    (sum_ok),
   .reloc_mode(reloc_mode)
);

// File: tb/cfg_cksum_loader_test.sv
module cfg_cksum_loader_test;

   localparam int ADDR_W = 6;
   localparam int DATA_W = 16;
   localparam int LAST   = 26;
   localparam int NW     = LAST + 1;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              rd_req;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;
   logic              rd_valid;
   logic              cfg_we;
   logic [ADDR_W-1:0] cfg_waddr;
   logic [DATA_W-1:0] cfg_wdata;
   logic              done;
   logic              sum_ok;
   logic              reloc_mode;

   always #10 clk = ~clk;

   cfg_cksum_loader uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_req    (rd_req),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid),
      .cfg_we    (cfg_we),
      .cfg_waddr (cfg_waddr),
      .cfg_wdata (cfg_wdata),
      .done      (done),
      .sum_ok    (sum_ok),
      .reloc_mode(reloc_mode)
   );

   typedef struct packed {
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
   } wr_item_t;

   int          checks = 0;
   int          errors = 0;
   int          writes_seen = 0;
   int          cycles = 0;
   logic [15:0] mem [NW];
   wr_item_t    exp_q [$];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] image_sum();
      logic [7:0] s = 8'h00;
      for (int i = 0; i < NW; i++) s = 8'(s + mem[i][7:0] + mem[i][15:8]);
      return s;
   endfunction

   // Adjust the low byte of the final word so the image sums to target.
   task automatic tune_to(input logic [7:0] target);
      logic [7:0] rest;
      mem[LAST][7:0] = 8'h00;
      rest = image_sum();
      mem[LAST][7:0] = 8'(target - rest);
   endtask

   function automatic int wait_of(input int mode, input int a);
      if (mode == 1) return a % 3;
      if (mode == 2) return (a * 5) % 4;
      return 0;
   endfunction

   // Monitor: pops expected writes as the design produces them.
   always @(negedge clk) begin
      cycles++;
      if (rst_n && cfg_we) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R8", "write with nothing accepted", 32'(cfg_waddr), 32'h0);
         end else begin
            wr_item_t it;
            it = exp_q.pop_front();
            check(cfg_waddr == it.a, "R4", "write address", 32'(cfg_waddr), 32'(it.a));
            check(cfg_wdata == it.d, "R4", "write data", 32'(cfg_wdata), 32'(it.d));
            writes_seen++;
            if (cfg_waddr != ADDR_W'(LAST))
               check(!done, "R6", "done before last word", 32'(done), 32'h0);
         end
      end
   end

   // Watchdog.
   always @(negedge clk) begin
      if (cycles > 100000) begin
         check(1'b0, "WDOG", "run hung", 32'(cycles), 32'h0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic run_image(input int mode, input string tag);
      logic [7:0] exp_sum;
      bit         exp_ok;
      int         wait_cnt;
      int         n;
      logic       d0, o0, r0;
      int         w0;
      exp_sum = image_sum();
      exp_ok  = (exp_sum == 8'hFF);
      rst_n    = 1'b0;
      rd_valid = 1'b0;
      rd_data  = 16'h0;
      exp_q.delete();
      writes_seen = 0;
      repeat (3) @(negedge clk);
      // R1
      check(!rd_req && !cfg_we, "R1", {tag, " req/we in reset"}, {rd_req, cfg_we}, 0);
      check(!done && !sum_ok && !reloc_mode, "R1", {tag, " flags in reset"},
            {done, sum_ok, reloc_mode}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2
      check(rd_req && rd_addr == 0, "R2", {tag, " first request"}, {rd_req, rd_addr}, {1'b1, 6'd0});
      wait_cnt = wait_of(mode, 0);
      n = 0;
      while (!done && n < 3000) begin
         if (rd_req) begin
            if (wait_cnt == 0 && int'(rd_addr) < NW) begin
               rd_valid = 1'b1;
               rd_data  = mem[rd_addr];
               exp_q.push_back({rd_addr, mem[rd_addr]});
               wait_cnt = wait_of(mode, int'(rd_addr) + 1);
            end else begin
               // R9: junk on the bus while not valid
               rd_valid = 1'b0;
               rd_data  = 16'hDEAD;
               if (wait_cnt > 0) wait_cnt--;
            end
         end else begin
            rd_valid = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      rd_valid = 1'b0;
      // R6
      check(done, "R6", {tag, " done reached"}, 32'(done), 32'h1);
      check(!rd_req, "R6", {tag, " request closed"}, 32'(rd_req), 32'h0);
      // R5, R7
      check(sum_ok == exp_ok, "R7", {tag, " sum_ok"}, 32'(sum_ok), 32'(exp_ok));
      check(reloc_mode == !exp_ok, "R5", {tag, " reloc_mode"}, 32'(reloc_mode), 32'(!exp_ok));
      d0 = done; o0 = sum_ok; r0 = reloc_mode;
      for (int k = 0; k < 4; k++) begin
         rd_valid = 1'b1;
         rd_data  = 16'(k * 16'h1111);
         @(negedge clk);
         // R8
         check(done == d0 && sum_ok == o0 && reloc_mode == r0, "R8", {tag, " frozen verdict"},
               {done, sum_ok, reloc_mode}, {d0, o0, r0});
      end
      rd_valid = 1'b0;
      @(negedge clk);
      w0 = writes_seen;
      // R4
      check(w0 == NW, "R4", {tag, " write count"}, 32'(w0), 32'(NW));
      check(exp_q.size() == 0, "R4", {tag, " writes outstanding"}, 32'(exp_q.size()), 32'h0);
   endtask

   initial begin
      rst_n    = 1'b0;
      rd_valid = 1'b0;
      rd_data  = 16'h0;

      // Image tuned to the good sum, no wait states.
      for (int i = 0; i < NW; i++) mem[i] = 16'(16'h1234 + i * 16'h0101);
      tune_to(8'hFF);
      run_image(0, "R5 good/nowait");

      // All zero: sum 0, fallback mode.
      for (int i = 0; i < NW; i++) mem[i] = 16'h0000;
      run_image(1, "R7 zero/wait");

      // All ones: every byte add carries, sum 0xCA.
      for (int i = 0; i < NW; i++) mem[i] = 16'hFFFF;
      run_image(2, "R5 carry/wait");

      // Good sum with address-dependent waits.
      for (int i = 0; i < NW; i++) mem[i] = {8'(i * 7), 8'(~i)};
      tune_to(8'hFF);
      run_image(1, "R9 good/wait");

      // One below the target.
      tune_to(8'hFE);
      run_image(0, "R7 off-by-one");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule